// File: doc/BRIEF.md
# SCSI DMA Channel Controller

This block is the bus-master DMA channel that sits between a storage protocol core and system memory. Software programs a start byte count, a start address and a start descriptor address through a word-wide register port, then issues a command. A start command loads those values into working copies, clears the status flags and enables the transfer. From then on, each burst that the protocol core asks for is issued on a request/grant memory interface. The burst address comes from the working address, and the burst length is capped at the remaining byte count. When memory grants the burst, the working count falls and the working address rises by the burst length.

A status word collects the channel's done, abort and error flags and merges in the protocol core's live interrupt line. An external mode input sets how the flags are cleared: either by writing ones to the status word, or as a side effect of reading it. An interrupt output is raised while the done flag is set and its enable bit in the command word is set.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Register words are read by index: 0 command (low 8 bits, zero-extended), 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address. Words 1, 2 and 6 are writable. Writes to words 3, 4 and 7 are ignored. Indices 8 and above read as zero.
- R2: After reset, the command word, the start registers, the working count and the status word read 0. The working address reads 0xFFFFFFFF and the working descriptor address reads 0xFFFFFFFD.
- R3: A command write whose bits [1:0] equal 3 (start) copies the start count, start address and start descriptor address into their working copies, clears every status flag, and drives `xfer_en` high from the next cycle.
- R4: Command bits [1:0] equal to 0 (idle) drive `xfer_en` low. A value of 1 (blast) changes no register and no output other than the stored command word. A value of 2 (abort) raises `abort_req` for exactly one cycle.
- R5: A burst request whose direction matches command bit 7 (1 = device-to-memory) raises `mem_req` on the next cycle. It carries `mem_addr` equal to the working address, `mem_len` equal to the smaller of the requested length and the working count, and `mem_dir` equal to the request direction. All of these are held until `mem_gnt`.
- R6: On the cycle `mem_gnt` meets `mem_req`, the working count drops and the working address rises by `mem_len`. `mem_req` falls and `bst_ack` pulses on the next cycle. Status bit 3 (done) is set when the working count reaches zero.
- R7: A burst request whose direction differs from command bit 7 is ignored: `mem_req` stays low and no register changes.
- R8: A status read returns bit 4 equal to the live `core_irq` input, ORed with the stored flags (bit 1 error, bit 2 abort, bit 3 done).
- R9: With `wr_clears` high, a write to the status word clears each of bits 1 to 3 that is written as 1, and status reads clear nothing.
- R10: With `wr_clears` low, a status read returns bits 1 to 3 and then clears them, and writes to the status word are ignored.
- R11: A `core_done` pulse forces the working count to zero and sets status bit 3.
- R12: `irq` is high exactly while status bit 3 is set and command bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| wr_clears | input | 1 | 1: status flags clear on write-one; 0: clear on read |
| core_irq | input | 1 | Interrupt line of the protocol core |
| core_done | input | 1 | Command-complete pulse from the protocol core |
| bst_req | input | 1 | Burst request from the protocol core |
| bst_dir | input | 1 | Burst direction, 1 = device-to-memory |
| bst_len | input | 16 | Requested burst length in bytes |
| bst_ack | output | 1 | One-cycle pulse after a burst is granted |
| mem_req | output | 1 | Memory burst request |
| mem_dir | output | 1 | Memory burst direction |
| mem_addr | output | 32 | Memory burst address |
| mem_len | output | 16 | Memory burst length |
| mem_gnt | input | 1 | Memory grant |
| xfer_en | output | 1 | Transfer enabled toward the protocol core |
| abort_req | output | 1 | One-cycle request to cancel the current transfer |
| irq | output | 1 | Done interrupt |

## Verification
Every result here is due one clock edge after its cause. Read data, `xfer_en`, `abort_req` and `mem_req` all appear at the edge that samples the strobe. The count and address update and the `bst_ack` pulse appear at the edge that samples the grant. The bench drives each strobe for exactly one cycle from the falling edge, then samples on the next falling edge. That is the first point where the registered result is visible, and for the one-cycle pulses it is the only point. A reference model of all eight words is updated after every operation, and a full read-back of the words follows directed and random stimulus alike.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  // register word indices
  localparam int W_CMD  = 0;
  localparam int W_SCNT = 1;
  localparam int W_SADR = 2;
  localparam int W_WCNT = 3;
  localparam int W_WADR = 4;
  localparam int W_STAT = 5;
  localparam int W_SDSC = 6;
  localparam int W_WDSC = 7;
  localparam int N_DMA_WORDS = 8;

  // command word bit positions
  localparam int CB_LIST    = 4;
  localparam int CB_PAGE_IE = 5;
  localparam int CB_DONE_IE = 6;
  localparam int CB_DIR     = 7;

  // status bit positions
  localparam int ST_PWDN = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_ABT  = 2;
  localparam int ST_DONE = 3;
  localparam int ST_CORE = 4;
  localparam int ST_BLT  = 5;
  localparam int ST_W    = 6;

  localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b00_1110;

  localparam logic [31:0] WADR_RST = 32'hFFFF_FFFF;
  localparam logic [31:0] WDSC_RST = 32'hFFFF_FFFD;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_q,
  output logic             start_p,
  output logic             xfer_en,
  output logic             abort_req
);

  dma_op_e op;
  logic    idle_p;
  logic    abort_p;

  assign op = dma_op_e'(cmd_wdata[1:0]);

  always_comb begin
    start_p = 1'b0;
    idle_p  = 1'b0;
    abort_p = 1'b0;
    if (cmd_wr) begin
      case (op)
        OP_IDLE:  idle_p  = 1'b1;
        OP_ABORT: abort_p = 1'b1;
        OP_START: start_p = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      xfer_en   <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      abort_req <= abort_p;
      if (cmd_wr) cmd_q <= cmd_wdata;
      if (start_p)     xfer_en <= 1'b1;
      else if (idle_p) xfer_en <= 1'b0;
    end
  end

  AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
    start_p |=> xfer_en); // R3
  AST_IDLE_STOPS: assert property (@(posedge clk) disable iff (rst)
    idle_p |=> !xfer_en); // R4
  AST_BLAST_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && op == OP_BLAST) |=> ($stable(xfer_en) && !abort_req)); // R4

endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit
  import dma_chan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_p,
  input  logic            set_done,
  input  logic            stat_wr,
  input  logic            stat_rd,
  input  logic            wr_clears,
  input  logic [ST_W-1:0] wdata,
  input  logic            core_irq,
  output logic [ST_W-1:0] stat_view,
  output logic            done
);

  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] clr;
  logic [ST_W-1:0] stat_d;

  always_comb begin
    clr = '0;
    if (stat_wr && wr_clears)  clr = clr | (wdata & ST_CLR_MASK);
    if (stat_rd && !wr_clears) clr = clr | ST_CLR_MASK;
    stat_d = stat_q & ~clr;
    if (set_done) stat_d[ST_DONE] = 1'b1;
    if (start_p)  stat_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  always_comb begin
    stat_view = stat_q;
    stat_view[ST_CORE] = stat_q[ST_CORE] | core_irq;
  end

  assign done = stat_q[ST_DONE];

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (stat_q == '0)); // R3
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    (set_done && !start_p) |=> done); // R11
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !wr_clears && !stat_rd && !start_p && !set_done) |=> $stable(stat_q)); // R10
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && wr_clears && !stat_wr && !start_p) |=> (stat_q[ST_DONE] || !$past(stat_q[ST_DONE]))); // R9

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
  import dma_chan_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scnt_wr,
  input  logic          sadr_wr,
  input  logic          sdsc_wr,
  input  logic [DW-1:0] wdata,
  input  logic          start_p,
  input  logic          core_done,
  input  logic          dir_cfg,
  input  logic          bst_req,
  input  logic          bst_dir,
  input  logic [LW-1:0] bst_len,
  input  logic          mem_gnt,
  output logic          mem_req,
  output logic          mem_dir,
  output logic [DW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  output logic          bst_ack,
  output logic          done_set,
  output logic [DW-1:0] s_cnt,
  output logic [DW-1:0] s_adr,
  output logic [DW-1:0] s_dsc,
  output logic [DW-1:0] w_cnt,
  output logic [DW-1:0] w_adr,
  output logic [DW-1:0] w_dsc
);

  logic          launch;
  logic          gnt_fire;
  logic [DW-1:0] req_len_ext;
  logic [DW-1:0] cur_len_ext;
  logic [LW-1:0] clamp_len;
  logic          drains;

  assign launch      = bst_req && !mem_req && (bst_dir == dir_cfg);
  assign gnt_fire    = mem_req && mem_gnt;
  assign req_len_ext = DW'(bst_len);
  assign cur_len_ext = DW'(mem_len);
  assign clamp_len   = (w_cnt < req_len_ext) ? w_cnt[LW-1:0] : bst_len;
  assign drains      = cur_len_ext >= w_cnt;
  assign done_set    = gnt_fire && drains;

  // shadow start registers
  always_ff @(posedge clk) begin
    if (rst) begin
      s_cnt <= '0;
      s_adr <= '0;
      s_dsc <= '0;
    end else begin
      if (scnt_wr) s_cnt <= wdata;
      if (sadr_wr) s_adr <= wdata;
      if (sdsc_wr) s_dsc <= wdata;
    end
  end

  // working registers
  always_ff @(posedge clk) begin
    if (rst) begin
      w_cnt <= '0;
      w_adr <= DW'(WADR_RST);
      w_dsc <= DW'(WDSC_RST);
    end else if (start_p) begin
      w_cnt <= s_cnt;
      w_adr <= s_adr;
      w_dsc <= s_dsc;
    end else begin
      if (gnt_fire) begin
        w_cnt <= drains ? '0 : (w_cnt - cur_len_ext);
        w_adr <= w_adr + cur_len_ext;
      end
      if (core_done) w_cnt <= '0;
    end
  end

  // memory side handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_dir  <= 1'b0;
      mem_addr <= '0;
      mem_len  <= '0;
      bst_ack  <= 1'b0;
    end else begin
      bst_ack <= 1'b0;
      if (launch) begin
        mem_req  <= 1'b1;
        mem_dir  <= bst_dir;
        mem_addr <= w_adr;
        mem_len  <= clamp_len;
      end else if (gnt_fire) begin
        mem_req <= 1'b0;
        bst_ack <= 1'b1;
      end
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_dir))); // R5
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (DW'(mem_len) <= $past(w_cnt))); // R5
  AST_ACK_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    gnt_fire |=> (bst_ack && !mem_req)); // R6
  AST_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bst_req && !mem_req && bst_dir != dir_cfg) |=> !mem_req); // R7
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (core_done && !start_p) |=> (w_cnt == '0)); // R11

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LW     = 16,
  parameter int ADDR_W = 4,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              wr_clears,
  input  logic              core_irq,
  input  logic              core_done,
  input  logic              bst_req,
  input  logic              bst_dir,
  input  logic [LW-1:0]     bst_len,
  output logic              bst_ack,
  output logic              mem_req,
  output logic              mem_dir,
  output logic [DW-1:0]     mem_addr,
  output logic [LW-1:0]     mem_len,
  input  logic              mem_gnt,
  output logic              xfer_en,
  output logic              abort_req,
  output logic              irq
);

  localparam int NWORDS = 1 << ADDR_W;

  logic [CMD_W-1:0] cmd_q;
  logic             start_p;
  logic             done_set;
  logic             stat_done;
  logic [ST_W-1:0]  stat_view;
  logic [DW-1:0]    s_cnt, s_adr, s_dsc, w_cnt, w_adr, w_dsc;
  logic [DW-1:0]    rd_words [NWORDS];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  dma_cmd_decode #(.CMD_W(CMD_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (reg_wr && hit(reg_addr, W_CMD)),
    .cmd_wdata (reg_wdata[CMD_W-1:0]),
    .cmd_q     (cmd_q),
    .start_p   (start_p),
    .xfer_en   (xfer_en),
    .abort_req (abort_req)
  );

  dma_burst_engine #(.DW(DW), .LW(LW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scnt_wr   (reg_wr && hit(reg_addr, W_SCNT)),
    .sadr_wr   (reg_wr && hit(reg_addr, W_SADR)),
    .sdsc_wr   (reg_wr && hit(reg_addr, W_SDSC)),
    .wdata     (reg_wdata),
    .start_p   (start_p),
    .core_done (core_done),
    .dir_cfg   (cmd_q[CB_DIR]),
    .bst_req   (bst_req),
    .bst_dir   (bst_dir),
    .bst_len   (bst_len),
    .mem_gnt   (mem_gnt),
    .mem_req   (mem_req),
    .mem_dir   (mem_dir),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .bst_ack   (bst_ack),
    .done_set  (done_set),
    .s_cnt     (s_cnt),
    .s_adr     (s_adr),
    .s_dsc     (s_dsc),
    .w_cnt     (w_cnt),
    .w_adr     (w_adr),
    .w_dsc     (w_dsc)
  );

  dma_status_unit u_stat (
    .clk       (clk),
    .rst       (rst),
    .start_p   (start_p),
    .set_done  (done_set || core_done),
    .stat_wr   (reg_wr && hit(reg_addr, W_STAT)),
    .stat_rd   (reg_rd && hit(reg_addr, W_STAT)),
    .wr_clears (wr_clears),
    .wdata     (reg_wdata[ST_W-1:0]),
    .core_irq  (core_irq),
    .stat_view (stat_view),
    .done      (stat_done)
  );

  assign irq = stat_done && cmd_q[CB_DONE_IE];

  // read view of the register words
  assign rd_words[W_CMD]  = DW'(cmd_q);
  assign rd_words[W_SCNT] = s_cnt;
  assign rd_words[W_SADR] = s_adr;
  assign rd_words[W_WCNT] = w_cnt;
  assign rd_words[W_WADR] = w_adr;
  assign rd_words[W_STAT] = DW'(stat_view);
  assign rd_words[W_SDSC] = s_dsc;
  assign rd_words[W_WDSC] = w_dsc;

  generate
    for (genvar g = N_DMA_WORDS; g < NWORDS; g++) begin : g_unmapped
      assign rd_words[g] = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_words[reg_addr];
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr >= ADDR_W'(N_DMA_WORDS)) |=> (reg_rdata == '0)); // R1
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !(reg_wr && hit(reg_addr, W_CMD))) |=> !abort_req); // R4

endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        wr_clears, core_irq, core_done;
  logic        bst_req, bst_dir;
  logic [15:0] bst_len;
  logic        bst_ack, mem_req, mem_dir, mem_gnt;
  logic [31:0] mem_addr;
  logic [15:0] mem_len;
  logic        xfer_en, abort_req, irq;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [7:0]  m_cmd;
  logic [31:0] m_scnt, m_sadr, m_sdsc, m_wcnt, m_wadr, m_wdsc;
  logic [5:0]  m_stat;
  logic        m_xfer;

  always #4 clk = ~clk;

  dma_chan_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_clears(wr_clears),
    .core_irq(core_irq), .core_done(core_done), .bst_req(bst_req), .bst_dir(bst_dir),
    .bst_len(bst_len), .bst_ack(bst_ack), .mem_req(mem_req), .mem_dir(mem_dir),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt), .xfer_en(xfer_en),
    .abort_req(abort_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_len(input logic [15:0] l, input logic [31:0] c);
    return (c < {16'h0, l}) ? c[15:0] : l;
  endfunction

  task automatic model_reset();
    m_cmd = '0; m_scnt = '0; m_sadr = '0; m_sdsc = '0;
    m_wcnt = '0; m_wadr = 32'hFFFF_FFFF; m_wdsc = 32'hFFFF_FFFD;
    m_stat = '0; m_xfer = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      4'd0: begin
        m_cmd = d[7:0];
        case (d[1:0])
          2'd0: m_xfer = 1'b0;
          2'd3: begin
            m_wcnt = m_scnt; m_wadr = m_sadr; m_wdsc = m_sdsc;
            m_stat = '0; m_xfer = 1'b1;
          end
          default: ;
        endcase
      end
      4'd1: m_scnt = d;
      4'd2: m_sadr = d;
      4'd6: m_sdsc = d;
      4'd5: if (wr_clears) m_stat = m_stat & ~(d[5:0] & 6'b001110);
      default: ;
    endcase
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_stat(input string req);
    logic [31:0] v;
    rreg(4'd5, v);
    chk(req, v, {26'h0, m_stat | {1'b0, core_irq, 4'b0}});
    if (!wr_clears) m_stat = m_stat & ~6'b001110;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rreg(4'd0, v); chk("R1 command word", v, {24'h0, m_cmd});
    rreg(4'd1, v); chk("R1 start count", v, m_scnt);
    rreg(4'd2, v); chk("R1 start address", v, m_sadr);
    rreg(4'd3, v); chk("R1 working count", v, m_wcnt);
    rreg(4'd4, v); chk("R1 working address", v, m_wadr);
    rreg(4'd6, v); chk("R1 start descriptor", v, m_sdsc);
    rreg(4'd7, v); chk("R1 working descriptor", v, m_wdsc);
    chk("R3 xfer_en", {31'h0, xfer_en}, {31'h0, m_xfer});
    chk("R12 irq", {31'h0, irq}, {31'h0, m_stat[3] & m_cmd[6]});
    chk_stat("R8 status word");
  endtask

  task automatic burst(input logic dir, input logic [15:0] len, input int waits);
    logic [15:0] el;
    @(negedge clk);
    bst_req = 1'b1; bst_dir = dir; bst_len = len;
    @(negedge clk);
    bst_req = 1'b0;
    if (dir != m_cmd[7]) begin
      chk("R7 mismatched burst ignored", {31'h0, mem_req}, 32'h0);
      return;
    end
    el = exp_len(len, m_wcnt);
    chk("R5 mem_req raised", {31'h0, mem_req}, 32'h1);
    chk("R5 mem_addr", mem_addr, m_wadr);
    chk("R5 mem_len clamp", {16'h0, mem_len}, {16'h0, el});
    chk("R5 mem_dir", {31'h0, mem_dir}, {31'h0, dir});
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R5 request held", {mem_req, 15'h0, mem_len}, {1'b1, 15'h0, el});
    end
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    chk("R6 bst_ack pulse", {30'h0, bst_ack, mem_req}, 32'h2);
    m_wcnt = m_wcnt - {16'h0, el};
    m_wadr = m_wadr + {16'h0, el};
    if (m_wcnt == 0) m_stat[3] = 1'b1;
  endtask

  task automatic pulse_core_done();
    @(negedge clk);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    m_wcnt = '0;
    m_stat[3] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    wr_clears = 0; core_irq = 0; core_done = 0;
    bst_req = 0; bst_dir = 0; bst_len = 0; mem_gnt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2 mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk("R2 xfer_en after reset", {31'h0, xfer_en}, 32'h0);
    check_all();
    rreg(4'd9, v);  chk("R1 unmapped word 9", v, 32'h0);
    rreg(4'd15, v); chk("R1 unmapped word 15", v, 32'h0);

    // R1 start registers writable, working ones not
    wreg(4'd1, 32'd100);
    wreg(4'd2, 32'h0001_0000);
    wreg(4'd6, 32'h0000_2000);
    wreg(4'd3, 32'hDEAD_BEEF);
    wreg(4'd4, 32'hCAFE_F00D);
    wreg(4'd7, 32'h1234_5678);
    wreg(4'd12, 32'h5555_5555);
    rreg(4'd12, v); chk("R1 unmapped write ignored", v, 32'h0);
    check_all();

    // R3 start, device-to-memory, done interrupt enabled
    wreg(4'd0, 32'h0000_00C3);
    chk("R3 start enables", {31'h0, xfer_en}, 32'h1);
    check_all();

    // R7 direction mismatch
    burst(1'b0, 16'd10, 0);
    check_all();

    // R5 R6 partial burst then clamped burst
    burst(1'b1, 16'd40, 2);
    check_all();
    burst(1'b1, 16'd500, 1);
    chk("R6 done at zero count", {28'h0, m_stat[3], 3'h0}, 32'h8);
    chk("R12 irq with done", {31'h0, irq}, 32'h1);

    // R10 clear-on-read, write ignored
    wr_clears = 1'b0;
    wreg(4'd5, 32'h0000_000E);
    chk_stat("R10 write ignored, done returned");
    chk_stat("R10 read cleared done");
    chk("R12 irq drops", {31'h0, irq}, 32'h0);

    // R11 and R9 write-one-to-clear
    wr_clears = 1'b1;
    wreg(4'd0, 32'h0000_00C3);
    pulse_core_done();
    chk_stat("R11 done after core completion");
    chk_stat("R9 read does not clear");
    wreg(4'd5, 32'h0000_0004);
    chk_stat("R9 unwritten bit kept");
    wreg(4'd5, 32'h0000_0008);
    chk_stat("R9 written one clears");
    rreg(4'd3, v); chk("R11 working count zero", v, 32'h0);

    // R8 live core interrupt
    core_irq = 1'b1;
    chk_stat("R8 core interrupt bit");
    core_irq = 1'b0;
    chk_stat("R8 core interrupt gone");

    // R4 blast, abort, idle
    wreg(4'd0, 32'h0000_00C1);
    chk("R4 blast keeps xfer_en", {31'h0, xfer_en}, 32'h1);
    chk("R4 blast no abort", {31'h0, abort_req}, 32'h0);
    check_all();
    wreg(4'd0, 32'h0000_00C2);
    chk("R4 abort pulse", {31'h0, abort_req}, 32'h1);
    @(negedge clk);
    chk("R4 abort single cycle", {31'h0, abort_req}, 32'h0);
    wreg(4'd0, 32'h0000_0040);
    chk("R4 idle stops", {31'h0, xfer_en}, 32'h0);
    check_all();

    // random mix
    for (int it = 0; it < 80; it++) begin
      case ($urandom % 7)
        0: wreg(4'd1, $urandom % 600);
        1: wreg(4'd2, $urandom);
        2: wreg(4'd6, $urandom);
        3: wreg(4'd0, {24'h0, 1'($urandom), 1'($urandom), 4'h0, 2'($urandom)});
        4: burst(1'($urandom), 16'($urandom % 300), $urandom % 3);
        5: pulse_core_done();
        default: begin
          wr_clears = 1'($urandom);
          core_irq  = 1'($urandom);
          if ($urandom % 2) wreg(4'd5, $urandom);
          check_all();
        end
      endcase
    end
    core_irq = 1'b0;
    check_all();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule